// File: doc/BRIEF.md
# Jam-Loaded Dual Down-Counter Divider

This block divides two edge streams for a frequency synthesizer loop. A reference stream and a VCO feedback stream reach it as single-cycle strobes in one system clock domain. A 15-bit reference down-counter and a 16-bit feedback down-counter each produce a pulse when they reach their terminal count. Those pulses feed a phase detector. Each pulse also appears on a test output that is enabled separately. A third output gives a divided copy of the reference input, with the division chosen by a 3-bit select field.

Writing a new feedback ratio raises `jam_load`. This reloads both counters together, so the two pulse trains restart in step. One cycle later the block sends a single-cycle reset to the phase detector. The reference pulse shaper is a three-state machine:

- `RS_IDLE` moves to `RS_FULL` on the terminal rising strobe.
- `RS_FULL` moves to `RS_HALF` on the fourth rising strobe after that.
- `RS_HALF` moves to `RS_IDLE` on the next falling strobe.
- A jam load forces any state back to `RS_IDLE`.

With a reference ratio of 1, the raw reference level passes straight through to the reference pulse output.

Top module: `lockstep_divider`

## Requirements
- R1: After reset the following are all low: `ref_pulse` (ratio other than 1), `fb_pulse`, `ref_test`, `fb_test`, `pd_reset` and `ref_out`. Both test enables reset to 0, and the reference-output select resets to 3'b100 (divide by 8).
- R2: Each `ref_rise` decrements the reference counter by one. After a jam load with ratio R (5 to 32767), `ref_pulse` rises one clock after the R-th `ref_rise`, and then repeats every R rises.
- R3: `ref_pulse` stays high for 4.5 reference cycles. It rises after the terminal `ref_rise` and falls one clock after the first `ref_fall` that follows the fourth later `ref_rise`.
- R4: When `ref_ratio` is 1, `ref_pulse` equals `ref_in` combinationally.
- R5: Reference ratios 0, 2, 3 and 4 behave exactly like ratio 5.
- R6: Each `vco_rise` decrements the feedback counter. After a jam load with ratio N (40 to 65535), `fb_pulse` is high for one clock, one clock after every N-th `vco_rise`.
- R7: Feedback ratios below 40 behave exactly like ratio 40.
- R8: `jam_load` reloads both counters from `ref_ratio` and `fb_ratio`, and ends any reference pulse in progress. The first pulses after a jam come after a full ratio of edges.
- R9: `pd_reset` is high for exactly the one clock that follows each `jam_load` clock.
- R10: On `cfg_load`, `cfg_ref_en` and `cfg_fb_en` are captured. While an enable is 0 its test output is held low. While it is 1 the test output follows `ref_pulse` or `fb_pulse` respectively.
- R11: On `cfg_load`, `cfg_refsel` is captured. The codes give these `ref_out` values:
  - 000: low
  - 001: `ref_in`
  - 010: reference divided by 2
  - 011: reference divided by 4
  - 100: reference divided by 8
  - 101: reference divided by 16
  - 110: reference divided by 8
  - 111: reference divided by 16

  Divided outputs change only after a `ref_rise`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference input level (used for bypass and the /1 output) |
| ref_rise | input | 1 | One-cycle strobe on a reference rising edge |
| ref_fall | input | 1 | One-cycle strobe on a reference falling edge |
| vco_rise | input | 1 | One-cycle strobe on a VCO rising edge |
| jam_load | input | 1 | Reload both counters (new feedback ratio written) |
| ref_ratio | input | 15 | Reference divide ratio |
| fb_ratio | input | 16 | Feedback divide ratio |
| cfg_load | input | 1 | Capture the configuration fields below |
| cfg_refsel | input | 3 | Reference-output divide select |
| cfg_fb_en | input | 1 | Feedback test output enable |
| cfg_ref_en | input | 1 | Reference test output enable |
| ref_pulse | output | 1 | Reference pulse to the phase detector |
| fb_pulse | output | 1 | Feedback pulse to the phase detector |
| ref_test | output | 1 | Gated reference pulse |
| fb_test | output | 1 | Gated feedback pulse |
| ref_out | output | 1 | Divided reference output |
| pd_reset | output | 1 | One-cycle phase detector reset after a jam |

## Verification
The assertions check several rules on every cycle:
- A reference or feedback pulse only begins in the clock after the matching rising strobe.
- The reference pulse only ends after a falling strobe or a jam.
- The counters never hold zero.
- A jam always leaves the shaper idle and the feedback pulse low.
- `pd_reset` appears exactly after a jam.
- The divided reference output only moves after a rising strobe.

Only the bench scenarios can show the things that need whole edge sequences:
- that the first pulses land on the exact R-th and N-th edge;
- the 4.5-cycle width;
- the clamping of small ratios;
- the exact count of edges on each reference-output select code.

// File: rtl/lockstep_divider_pkg.sv
package lockstep_divider_pkg;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_FULL = 2'd1,
        RS_HALF = 2'd2
    } ref_state_e;

    localparam logic [2:0] SEL_OFF  = 3'b000;
    localparam logic [2:0] SEL_PASS = 3'b001;
    localparam logic [2:0] SEL_DEFAULT = 3'b100;

endpackage

// File: rtl/ref_divider.sv
module ref_divider
    import lockstep_divider_pkg::*;
#(
    parameter int W     = 15,
    parameter int MINR  = 5,
    parameter int RISES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ref_in,
    input  logic         ref_rise,
    input  logic         ref_fall,
    input  logic         jam,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    localparam int WCW = (RISES > 1) ? $clog2(RISES) : 1;
    localparam logic [WCW-1:0] LAST_WC = WCW'(RISES - 1);
    localparam logic [W-1:0]   ONE     = W'(1);

    ref_state_e     state_q, state_d;
    logic [W-1:0]   cnt_q;
    logic [W-1:0]   eff_ratio;
    logic [WCW-1:0] wc_q;
    logic           bypass;
    logic           terminal;

    always_comb begin
        if (ratio == ONE)
            eff_ratio = ONE;
        else if (ratio < W'(MINR))
            eff_ratio = W'(MINR);
        else
            eff_ratio = ratio;
    end

    assign bypass   = (ratio == ONE);
    assign terminal = ref_rise && (cnt_q == ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '1;
        else if (jam)
            cnt_q <= eff_ratio;
        else if (ref_rise)
            cnt_q <= (cnt_q == ONE) ? eff_ratio : cnt_q - ONE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (terminal) state_d = RS_FULL;
            RS_FULL: if (ref_rise && wc_q == LAST_WC) state_d = RS_HALF;
            RS_HALF: if (ref_fall) state_d = RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RS_IDLE;
        else if (jam)
            state_q <= RS_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wc_q <= '0;
        else if (jam || state_q != RS_FULL)
            wc_q <= '0;
        else if (ref_rise)
            wc_q <= wc_q + WCW'(1);
    end

    always_comb begin
        if (bypass)
            pulse = ref_in;
        else
            pulse = (state_q != RS_IDLE);
    end

    AST_REF_ROSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && $past(!bypass) && $rose(pulse)) |-> $past(ref_rise)); // R2

    AST_REF_FALL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && $past(!bypass) && $fell(pulse)) |-> ($past(ref_fall) || $past(jam))); // R3

    AST_REF_JAM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        jam |=> (state_q == RS_IDLE)); // R8

    AST_REF_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0); // R5

endmodule

// File: rtl/fb_divider.sv
module fb_divider #(
    parameter int W    = 16,
    parameter int MINF = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vco_rise,
    input  logic         jam,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] eff_ratio;
    logic         pulse_q;

    assign eff_ratio = (ratio < W'(MINF)) ? W'(MINF) : ratio;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '1;
            pulse_q <= 1'b0;
        end else if (jam) begin
            cnt_q   <= eff_ratio;
            pulse_q <= 1'b0;
        end else if (vco_rise) begin
            if (cnt_q == ONE) begin
                cnt_q   <= eff_ratio;
                pulse_q <= 1'b1;
            end else begin
                cnt_q   <= cnt_q - ONE;
                pulse_q <= 1'b0;
            end
        end else begin
            pulse_q <= 1'b0;
        end
    end

    assign pulse = pulse_q;

    AST_FB_PULSE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(vco_rise)); // R6

    AST_FB_JAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        jam |=> !pulse); // R8

    AST_FB_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0); // R7

endmodule

// File: rtl/refout_prescaler.sv
module refout_prescaler
    import lockstep_divider_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       ref_rise,
    input  logic [2:0] sel,
    output logic       refout
);
    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (ref_rise)
            div_q <= div_q + PW'(1);
    end

    always_comb begin
        unique case (sel)
            3'b000:  refout = 1'b0;
            3'b001:  refout = ref_in;
            3'b010:  refout = div_q[0];
            3'b011:  refout = div_q[1];
            3'b100,
            3'b110:  refout = div_q[2];
            default: refout = div_q[3];
        endcase
    end

    AST_REFOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ref_rise) && $stable(sel) && sel != SEL_PASS) |-> $stable(refout)); // R11

endmodule

// File: rtl/lockstep_divider.sv
module lockstep_divider
    import lockstep_divider_pkg::*;
#(
    parameter int REF_W     = 15,
    parameter int FB_W      = 16,
    parameter int REF_MIN   = 5,
    parameter int FB_MIN    = 40,
    parameter int PULSE_RISES = 4,
    parameter int PRE_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             ref_rise,
    input  logic             ref_fall,
    input  logic             vco_rise,
    input  logic             jam_load,
    input  logic [REF_W-1:0] ref_ratio,
    input  logic [FB_W-1:0]  fb_ratio,
    input  logic             cfg_load,
    input  logic [2:0]       cfg_refsel,
    input  logic             cfg_fb_en,
    input  logic             cfg_ref_en,
    output logic             ref_pulse,
    output logic             fb_pulse,
    output logic             ref_test,
    output logic             fb_test,
    output logic             ref_out,
    output logic             pd_reset
);
    logic [2:0] refsel_q;
    logic       fb_en_q;
    logic       ref_en_q;
    logic       pd_reset_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            refsel_q <= SEL_DEFAULT;
            fb_en_q  <= 1'b0;
            ref_en_q <= 1'b0;
        end else if (cfg_load) begin
            refsel_q <= cfg_refsel;
            fb_en_q  <= cfg_fb_en;
            ref_en_q <= cfg_ref_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pd_reset_q <= 1'b0;
        else
            pd_reset_q <= jam_load;
    end

    ref_divider #(
        .W     (REF_W),
        .MINR  (REF_MIN),
        .RISES (PULSE_RISES)
    ) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .ref_rise (ref_rise),
        .ref_fall (ref_fall),
        .jam      (jam_load),
        .ratio    (ref_ratio),
        .pulse    (ref_pulse)
    );

    fb_divider #(
        .W    (FB_W),
        .MINF (FB_MIN)
    ) u_fb (
        .clk      (clk),
        .rst_n    (rst_n),
        .vco_rise (vco_rise),
        .jam      (jam_load),
        .ratio    (fb_ratio),
        .pulse    (fb_pulse)
    );

    refout_prescaler #(
        .PW (PRE_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .ref_rise (ref_rise),
        .sel      (refsel_q),
        .refout   (ref_out)
    );

    assign ref_test = ref_en_q & ref_pulse;
    assign fb_test  = fb_en_q & fb_pulse;
    assign pd_reset = pd_reset_q;

    AST_PD_AFTER_JAM: assert property (@(posedge clk) disable iff (!rst_n)
        jam_load |=> pd_reset); // R9

    AST_PD_ONLY_JAM: assert property (@(posedge clk) disable iff (!rst_n)
        pd_reset |-> $past(jam_load)); // R9

    AST_TEST_LOW_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_load) && !$past(fb_en_q) && $past(!fb_test)) |-> !fb_test); // R10

endmodule

// File: tb/test_lockstep_divider.sv
module test_lockstep_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0, ref_rise = 1'b0, ref_fall = 1'b0, vco_rise = 1'b0;
    logic        jam_load = 1'b0, cfg_load = 1'b0;
    logic [14:0] ref_ratio = 15'd5;
    logic [15:0] fb_ratio = 16'd40;
    logic [2:0]  cfg_refsel = 3'b100;
    logic        cfg_fb_en = 1'b0, cfg_ref_en = 1'b0;
    logic        ref_pulse, fb_pulse, ref_test, fb_test, ref_out, pd_reset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lockstep_divider i_lockstep_divider (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .ref_rise(ref_rise),
        .ref_fall(ref_fall), .vco_rise(vco_rise), .jam_load(jam_load),
        .ref_ratio(ref_ratio), .fb_ratio(fb_ratio), .cfg_load(cfg_load),
        .cfg_refsel(cfg_refsel), .cfg_fb_en(cfg_fb_en), .cfg_ref_en(cfg_ref_en),
        .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .ref_test(ref_test),
        .fb_test(fb_test), .ref_out(ref_out), .pd_reset(pd_reset)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic jam(output int pd1, output int pd2, output int rp);
        @(negedge clk); jam_load = 1'b1;
        @(negedge clk); jam_load = 1'b0;
        pd1 = pd_reset; rp = ref_pulse;
        @(negedge clk); pd2 = pd_reset;
    endtask

    task automatic cfg(input logic [2:0] sel, input logic fen, input logic ren);
        @(negedge clk);
        cfg_refsel = sel; cfg_fb_en = fen; cfg_ref_en = ren; cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
    endtask

    task automatic run_ref(input int n, output int r1, output int r2, output int highs,
                           output int thighs, output int byp_bad, output int ro_rises);
        logic prev, prev_ro;
        r1 = 0; r2 = 0; highs = 0; thighs = 0; byp_bad = 0; ro_rises = 0;
        prev = ref_pulse; prev_ro = ref_out;
        for (int c = 1; c <= n; c++) begin
            for (int s = 0; s < 6; s++) begin
                @(negedge clk);
                if (ref_pulse) highs++;
                if (ref_test) thighs++;
                if (ref_pulse !== ref_in) byp_bad++;
                if (ref_pulse && !prev) begin
                    if (r1 == 0) r1 = c; else if (r2 == 0) r2 = c;
                end
                if (ref_out && !prev_ro) ro_rises++;
                prev = ref_pulse; prev_ro = ref_out;
                case (s)
                    0: begin ref_in = 1'b1; ref_rise = 1'b1; end
                    1: ref_rise = 1'b0;
                    3: begin ref_in = 1'b0; ref_fall = 1'b1; end
                    4: ref_fall = 1'b0;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic run_vco(input int n, output int r1, output int r2, output int highs,
                           output int thighs);
        r1 = 0; r2 = 0; highs = 0; thighs = 0;
        for (int t = 1; t <= n; t++) begin
            @(negedge clk);
            if (fb_pulse) highs++;
            if (fb_test) thighs++;
            vco_rise = 1'b1;
            @(negedge clk);
            vco_rise = 1'b0;
            if (fb_pulse) begin
                highs++;
                if (r1 == 0) r1 = t; else if (r2 == 0) r2 = t;
            end
            if (fb_test) thighs++;
        end
    endtask

    task automatic test_reset();
        int r1, r2, h, th, bb, ro, p1, p2, rp;
        chk(ref_pulse == 0 && fb_pulse == 0, "R1 pulses low", ref_pulse + fb_pulse, 0);
        chk(ref_test == 0 && fb_test == 0, "R1 tests low", ref_test + fb_test, 0);
        chk(pd_reset == 0 && ref_out == 0, "R1 pd_reset/ref_out low", pd_reset + ref_out, 0);
        ref_ratio = 15'd5;
        jam(p1, p2, rp);
        run_ref(32, r1, r2, h, th, bb, ro);
        chk(ro == 4, "R1 default select /8 rises in 32", ro, 4);
        chk(th == 0, "R1 ref test disabled at reset", th, 0);
    endtask

    task automatic test_ref_period();
        int r1, r2, h, th, bb, ro, p1, p2, rp;
        ref_ratio = 15'd7;
        jam(p1, p2, rp);
        run_ref(18, r1, r2, h, th, bb, ro);
        chk(r1 == 7, "R2 first ref pulse at rise 7", r1, 7);
        chk(r2 == 14, "R2 second ref pulse at rise 14", r2, 14);
        chk(h == 54, "R3 two pulses of 4.5 cycles (27 clk each)", h, 54);
        ref_ratio = 15'd5;
        jam(p1, p2, rp);
        run_ref(14, r1, r2, h, th, bb, ro);
        chk(r1 == 5 && r2 == 10, "R2 ratio 5 pulse at rise 5", r1, 5);
        chk(h == 54, "R3 width at minimum ratio", h, 54);
    endtask

    task automatic test_ref_clamp();
        int r1, r2, h, th, bb, ro, p1, p2, rp;
        ref_ratio = 15'd3;
        jam(p1, p2, rp);
        run_ref(14, r1, r2, h, th, bb, ro);
        chk(r1 == 5 && r2 == 10, "R5 ratio 3 acts as 5", r1, 5);
        ref_ratio = 15'd0;
        jam(p1, p2, rp);
        run_ref(14, r1, r2, h, th, bb, ro);
        chk(r1 == 5 && h == 54, "R5 ratio 0 acts as 5", r1, 5);
    endtask

    task automatic test_ref_bypass();
        int r1, r2, h, th, bb, ro, p1, p2, rp;
        ref_ratio = 15'd1;
        jam(p1, p2, rp);
        run_ref(4, r1, r2, h, th, bb, ro);
        chk(bb == 0, "R4 bypass follows ref_in", bb, 0);
        chk(h == 12, "R4 bypass high samples", h, 12);
    endtask

    task automatic test_fb();
        int r1, r2, h, th, p1, p2, rp;
        fb_ratio = 16'd40;
        jam(p1, p2, rp);
        run_vco(84, r1, r2, h, th);
        chk(r1 == 40 && r2 == 80, "R6 fb pulse at rise 40 and 80", r1, 40);
        chk(h == 2, "R6 fb pulse one clock each", h, 2);
        fb_ratio = 16'd100;
        jam(p1, p2, rp);
        run_vco(100, r1, r2, h, th);
        chk(r1 == 100 && h == 1, "R6 ratio 100", r1, 100);
        fb_ratio = 16'd10;
        jam(p1, p2, rp);
        run_vco(45, r1, r2, h, th);
        chk(r1 == 40 && h == 1, "R7 ratio 10 acts as 40", r1, 40);
    endtask

    task automatic test_jam();
        int r1, r2, h, th, bb, ro, p1, p2, rp;
        fb_ratio = 16'd40;
        jam(p1, p2, rp);
        chk(p1 == 1 && p2 == 0, "R9 pd_reset single clock", p1 * 10 + p2, 10);
        run_vco(25, r1, r2, h, th);
        jam(p1, p2, rp);
        run_vco(45, r1, r2, h, th);
        chk(r1 == 40, "R8 fb counter restarts after jam", r1, 40);
        ref_ratio = 15'd7;
        jam(p1, p2, rp);
        run_ref(3, r1, r2, h, th, bb, ro);
        jam(p1, p2, rp);
        run_ref(18, r1, r2, h, th, bb, ro);
        chk(r1 == 7 && r2 == 14, "R8 ref counter restarts after jam", r1, 7);
        ref_ratio = 15'd5;
        jam(p1, p2, rp);
        run_ref(6, r1, r2, h, th, bb, ro);
        chk(ref_pulse == 1, "R8 ref pulse in progress before jam", ref_pulse, 1);
        jam(p1, p2, rp);
        chk(rp == 0, "R8 jam ends ref pulse", rp, 0);
        chk(p1 == 1 && p2 == 0, "R9 pd_reset after second jam", p1 * 10 + p2, 10);
    endtask

    task automatic test_enables();
        int r1, r2, h, th, bb, ro, p1, p2, rp;
        cfg(3'b100, 1'b1, 1'b1);
        fb_ratio = 16'd40; ref_ratio = 15'd5;
        jam(p1, p2, rp);
        run_vco(40, r1, r2, h, th);
        chk(th == 1 && h == 1, "R10 fb test follows pulse when enabled", th, 1);
        run_ref(14, r1, r2, h, th, bb, ro);
        chk(th == h && h == 54, "R10 ref test follows pulse when enabled", th, 54);
        cfg(3'b100, 1'b0, 1'b0);
        jam(p1, p2, rp);
        run_vco(40, r1, r2, h, th);
        chk(th == 0 && h == 1, "R10 fb test low when disabled", th, 0);
        run_ref(14, r1, r2, h, th, bb, ro);
        chk(th == 0 && h == 54, "R10 ref test low when disabled", th, 0);
    endtask

    task automatic test_refout();
        int r1, r2, h, th, bb, ro;
        int exp_r [8] = '{0, 32, 16, 8, 4, 2, 4, 2};
        ref_ratio = 15'd5;
        for (int k = 0; k < 8; k++) begin
            cfg(3'(k), 1'b0, 1'b0);
            run_ref(32, r1, r2, h, th, bb, ro);
            chk(ro == exp_r[k], $sformatf("R11 ref_out rises for select %0d", k), ro, exp_r[k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_ref_period();
        test_ref_clamp();
        test_ref_bypass();
        test_fb();
        test_jam();
        test_enables();
        test_refout();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule